// File: doc/BRIEF.md
# Locked Read-Modify-Write Sequencer

This block runs one indivisible read-modify-write on behalf of a core's private data cache. A request names a byte address, an operand size and an operation: add, exchange or compare-exchange. In the normal case the sequencer first obtains the target line in Modified state. It then reads the old value, computes the new one and writes it back. From the read until the write it refuses coherence snoops aimed at that line, so no other agent can observe or change the line partway through the operation.

If the operand spans two 64-byte lines, holding a single line cannot make the access indivisible. The sequencer then skips line acquisition. It asks for the system bus lock instead, and after the grant it keeps that lock asserted through the read, the modify and the write. Snoops to either of the two lines are refused during that window. The old memory value returns on the response port together with a one-cycle done pulse. Only one locked operation can be in flight at a time.

Top module: `atomic_rmw_lockctl`

## Requirements
- R1: `req_ready` is high only when no operation is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` stays low from then until the done pulse.
- R2: For an operand that stays in one line, `acq_req` is raised with `acq_line` equal to the address bits above the 6 offset bits. It stays high until a cycle with `acq_gnt` high, and no cache read is issued before that grant.
- R3: After the grant, `mem_rd` is high for exactly one cycle. The cache returns the data one cycle later, and any write (`mem_wr`) follows one cycle after that, so one write at most is issued per operation.
- R4: For a single-line operand, a snoop whose `snoop_line` equals the held line sees `snp_stall` high in each of the three cycles of read, modify and write.
- R5: A snoop to any other line is never stalled. A snoop to the target line is not stalled before the grant, and it is not stalled in the done cycle.
- R6: Sizes are encoded as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. An operand is split when the 64-byte line number of its first byte differs from that of its last byte.
- R7: For a split operand, `bus_lock_req` is raised and `acq_req` is never raised. After `bus_lock_gnt`, `bus_lock` stays high for four consecutive cycles: the cycle after the grant, then read, modify and write. Snoops to either of the two lines are stalled in those four cycles.
- R8: Operations are encoded as 0=add, 1=exchange and 2=compare-exchange, with 3 treated as exchange. The memory value, operand and compare value are cut to the operand size, and the add wraps at that size.
- R9: A compare-exchange whose truncated memory value differs from the truncated compare value writes nothing, but still runs the full sequence, including the snoop stall window.
- R10: `rsp_done` is a one-cycle pulse with `rsp_old` holding the truncated, zero-extended old value. `req_ready` is high again in the next cycle.
- R11: While reset is high and just after it, `req_ready` is high and `rsp_done`, `acq_req`, `mem_rd`, `mem_wr`, `bus_lock_req`, `bus_lock` and `snp_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Locked operation request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_op | input | 2 | Operation code |
| req_operand | input | DATA_W | Addend or new value |
| req_compare | input | DATA_W | Expected value for compare-exchange |
| rsp_done | output | 1 | Operation finished (one cycle) |
| rsp_old | output | DATA_W | Old memory value, zero-extended |
| acq_req | output | 1 | Request line in Modified state |
| acq_line | output | ADDR_W-6 | Line number to acquire |
| acq_gnt | input | 1 | Line is held in Modified state |
| mem_rd | output | 1 | Cache read strobe |
| mem_wr | output | 1 | Cache write strobe |
| mem_addr | output | ADDR_W | Cache access byte address |
| mem_size | output | 2 | Cache access size code |
| mem_wr_data | output | DATA_W | Write data, right-aligned |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after `mem_rd` |
| snp_valid | input | 1 | Incoming coherence snoop |
| snoop_line | input | ADDR_W-6 | Line number of the snoop |
| snp_stall | output | 1 | Snoop refused this cycle |
| bus_lock_req | output | 1 | Request for the system bus lock |
| bus_lock_gnt | input | 1 | Bus lock granted |
| bus_lock | output | 1 | Bus lock asserted, other agents blocked |

## Verification
The bench goes after line-boundary corners: a 4-byte operand that ends exactly on a line's last byte, one shifted a byte further, and a 1-byte and a 2-byte access at offset 63. A design that tested only the start address, or that was off by one on the last byte, would take the wrong path: it would either reach for the bus lock without need or hold one line while the other stays exposed. Each operation runs under a steady snoop to the held line, to the neighbouring line or to an unrelated line, and the stall cycles are counted. A window that is one cycle short or long, a stall that leaks into the grant wait or the done cycle, or a neighbour stalled in single-line mode all change that count. Truncated adds that overflow, a compare-exchange that misses and still has to hold the line, and back-pressure while the grant is withheld cover the remaining paths.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_ACQUIRE   = 4'd1,
    ST_BLK_REQ   = 4'd2,
    ST_BLK_HOLD  = 4'd3,
    ST_LOAD      = 4'd4,
    ST_MODIFY    = 4'd5,
    ST_STORE     = 4'd6,
    ST_RELEASE   = 4'd7
  } rmw_state_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XCHG = 2'd1,
    OP_CMPX = 2'd2,
    OP_RSVD = 2'd3
  } rmw_op_e;

endpackage

// File: rtl/rmw_split_chk.sv
module rmw_split_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SZ_W       = 2
) (
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [SZ_W-1:0]                        size,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   first_line,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   last_line,
  output logic                                   split
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] last_byte;
  logic [ADDR_W-1:0] span;

  always_comb begin
    span       = (ADDR_W'(1) << size) - ADDR_W'(1);
    last_byte  = addr + span;
    first_line = addr[ADDR_W-1:OFF_W];
    last_line  = last_byte[ADDR_W-1:OFF_W];
    split      = (first_line != last_line);
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2
) (
  input  logic [1:0]        op,
  input  logic [SZ_W-1:0]   size,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] compare,
  output logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] opnd_m;
  logic [DATA_W-1:0] cmp_m;
  logic              match;

  // Byte-lane mask built per bit, so any DATA_W that is a power of two works.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask[b] = (b < (8 << size));
  end

  always_comb begin
    old_val  = mem_val & mask;
    opnd_m   = operand & mask;
    cmp_m    = compare & mask;
    match    = (old_val == cmp_m);
    new_val  = opnd_m;
    do_write = 1'b1;
    case (rmw_op_e'(op))
      OP_ADD:  new_val = (old_val + opnd_m) & mask;
      OP_CMPX: begin
        new_val  = match ? opnd_m : old_val;
        do_write = match;
      end
      default: new_val = opnd_m;
    endcase
  end
endmodule

// File: rtl/rmw_snoop_gate.sv
module rmw_snoop_gate #(
  parameter int LINE_W = 26,
  parameter int LANES  = 2
) (
  input  logic                          snp_valid,
  input  logic [LINE_W-1:0]             snoop_line,
  input  logic [LANES-1:0]              lane_on,
  input  logic [LANES-1:0][LINE_W-1:0]  lane_line,
  output logic                          stall
);
  logic [LANES-1:0] hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l] = lane_on[l] && (lane_line[l] == snoop_line);
  end

  assign stall = snp_valid && (|hit);
endmodule

// File: rtl/atomic_rmw_lockctl.sv
module atomic_rmw_lockctl
  import rmw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [1:0]                           req_size,
  input  logic [1:0]                           req_op,
  input  logic [DATA_W-1:0]                    req_operand,
  input  logic [DATA_W-1:0]                    req_compare,
  output logic                                 rsp_done,
  output logic [DATA_W-1:0]                    rsp_old,
  output logic                                 acq_req,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] acq_line,
  input  logic                                 acq_gnt,
  output logic                                 mem_rd,
  output logic                                 mem_wr,
  output logic [ADDR_W-1:0]                    mem_addr,
  output logic [1:0]                           mem_size,
  output logic [DATA_W-1:0]                    mem_wr_data,
  input  logic [DATA_W-1:0]                    mem_rd_data,
  input  logic                                 snp_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snoop_line,
  output logic                                 snp_stall,
  output logic                                 bus_lock_req,
  input  logic                                 bus_lock_gnt,
  output logic                                 bus_lock
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int SZ_W   = 2;
  localparam int LANES  = 2;

  rmw_state_e state_q, state_d;

  // Captured request
  logic [ADDR_W-1:0] addr_q;
  logic [SZ_W-1:0]   size_q;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] cmp_q;
  logic [LINE_W-1:0] lo_line_q;
  logic [LINE_W-1:0] hi_line_q;
  logic              split_q;

  // Results of the modify step
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] new_q;
  logic              wr_en_q;

  // Split detection on the incoming request
  logic [LINE_W-1:0] in_lo_line;
  logic [LINE_W-1:0] in_hi_line;
  logic              in_split;

  rmw_split_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .SZ_W       (SZ_W)
  ) u_split (
    .addr       (req_addr),
    .size       (req_size),
    .first_line (in_lo_line),
    .last_line  (in_hi_line),
    .split      (in_split)
  );

  // Operation datapath on the value returned by the cache
  logic [DATA_W-1:0] alu_old;
  logic [DATA_W-1:0] alu_new;
  logic              alu_wr;

  rmw_alu #(
    .DATA_W (DATA_W),
    .SZ_W   (SZ_W)
  ) u_alu (
    .op       (op_q),
    .size     (size_q),
    .mem_val  (mem_rd_data),
    .operand  (opnd_q),
    .compare  (cmp_q),
    .old_val  (alu_old),
    .new_val  (alu_new),
    .do_write (alu_wr)
  );

  // Hold window: line mode covers load..store, split mode adds the grant cycle
  logic core_win;
  logic split_win;
  logic line_win;

  always_comb begin
    core_win  = (state_q == ST_LOAD) || (state_q == ST_MODIFY) || (state_q == ST_STORE);
    split_win = split_q && (core_win || (state_q == ST_BLK_HOLD));
    line_win  = !split_q && core_win;
  end

  logic [LANES-1:0]             lane_on;
  logic [LANES-1:0][LINE_W-1:0] lane_line;

  always_comb begin
    lane_on[0]   = line_win || split_win;
    lane_on[1]   = split_win;
    lane_line[0] = lo_line_q;
    lane_line[1] = hi_line_q;
  end

  rmw_snoop_gate #(
    .LINE_W (LINE_W),
    .LANES  (LANES)
  ) u_snoop (
    .snp_valid  (snp_valid),
    .snoop_line (snoop_line),
    .lane_on    (lane_on),
    .lane_line  (lane_line),
    .stall      (snp_stall)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid) state_d = in_split ? ST_BLK_REQ : ST_ACQUIRE;
      ST_ACQUIRE:  if (acq_gnt) state_d = ST_LOAD;
      ST_BLK_REQ:  if (bus_lock_gnt) state_d = ST_BLK_HOLD;
      ST_BLK_HOLD: state_d = ST_LOAD;
      ST_LOAD:     state_d = ST_MODIFY;
      ST_MODIFY:   state_d = ST_STORE;
      ST_STORE:    state_d = ST_RELEASE;
      ST_RELEASE:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      size_q    <= '0;
      op_q      <= '0;
      opnd_q    <= '0;
      cmp_q     <= '0;
      lo_line_q <= '0;
      hi_line_q <= '0;
      split_q   <= 1'b0;
    end else if (state_q == ST_IDLE && req_valid) begin
      addr_q    <= req_addr;
      size_q    <= req_size;
      op_q      <= req_op;
      opnd_q    <= req_operand;
      cmp_q     <= req_compare;
      lo_line_q <= in_lo_line;
      hi_line_q <= in_hi_line;
      split_q   <= in_split;
    end
  end

  // Modify step: read data arrives in the cycle after the read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      old_q   <= '0;
      new_q   <= '0;
      wr_en_q <= 1'b0;
    end else if (state_q == ST_MODIFY) begin
      old_q   <= alu_old;
      new_q   <= alu_new;
      wr_en_q <= alu_wr;
    end
  end

  // Outputs decoded straight from state flops
  always_comb begin
    req_ready    = (state_q == ST_IDLE);
    acq_req      = (state_q == ST_ACQUIRE);
    acq_line     = lo_line_q;
    bus_lock_req = split_q && ((state_q == ST_BLK_REQ) || split_win);
    bus_lock     = split_win;
    mem_rd       = (state_q == ST_LOAD);
    mem_wr       = (state_q == ST_STORE) && wr_en_q;
    mem_addr     = addr_q;
    mem_size     = size_q;
    mem_wr_data  = new_q;
    rsp_done     = (state_q == ST_RELEASE);
    rsp_old      = old_q;
  end
endmodule

// File: rtl/rmw_lockctl_chk.sv
module rmw_lockctl_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 req_ready,
  input logic                                 rsp_done,
  input logic                                 acq_req,
  input logic                                 acq_gnt,
  input logic                                 mem_rd,
  input logic                                 mem_wr,
  input logic [ADDR_W-1:0]                    mem_addr,
  input logic                                 snp_valid,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snoop_line,
  input logic                                 snp_stall,
  input logic                                 bus_lock_req,
  input logic                                 bus_lock_gnt,
  input logic                                 bus_lock
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R1: idle means no line request and no bus lock
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!acq_req && !bus_lock && !mem_rd && !mem_wr));

  // R2: single-line read only follows a granted acquisition
  a_r2_rd_after_gnt: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !bus_lock) |-> $past(acq_req && acq_gnt));

  // R3: a write is always two cycles after the read
  a_r3_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd, 2));

  // R3: read strobe lasts one cycle
  a_r3_rd_single: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R4: snoop to the held line during read is refused
  a_r4_stall_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && snp_valid && snoop_line == mem_addr[ADDR_W-1:OFF_W]) |-> snp_stall);

  // R5: no stall in the done cycle
  a_r5_done_free: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !snp_stall);

  // R7: bus lock starts only after a granted request
  a_r7_lock_after_gnt: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_lock) |-> $past(bus_lock_req && bus_lock_gnt));

  // R7: split path never acquires a line
  a_r7_no_acq_split: assert property (@(posedge clk) disable iff (rst)
    bus_lock_req |-> !acq_req);

  // R7: bus lock held across the read
  a_r7_lock_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && bus_lock) |=> bus_lock);

  // R10: done is a single pulse followed by ready
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> (!rsp_done && req_ready));
endmodule

bind atomic_rmw_lockctl rmw_lockctl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .rsp_done     (rsp_done),
  .acq_req      (acq_req),
  .acq_gnt      (acq_gnt),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .mem_addr     (mem_addr),
  .snp_valid    (snp_valid),
  .snoop_line   (snoop_line),
  .snp_stall    (snp_stall),
  .bus_lock_req (bus_lock_req),
  .bus_lock_gnt (bus_lock_gnt),
  .bus_lock     (bus_lock)
);

// File: tb/atomic_rmw_lockctl_tb_top.sv
module atomic_rmw_lockctl_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int LINE_W = ADDR_W - 6;
  localparam logic [DATA_W-1:0] POISON = 64'hDEAD_BEEF_CAFE_F00D;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic [1:0]        op;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] cmp;
    logic [DATA_W-1:0] mem;
    logic              snp_on;
    logic [LINE_W-1:0] snp_line;
    logic [DATA_W-1:0] exp_old;
    logic [DATA_W-1:0] exp_new;
    logic              exp_wr;
    logic              exp_split;
    logic [3:0]        exp_stall;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{32'h100, 2'd3, 2'd0, 64'd5, 64'd0, 64'd10, 1'b1, 26'd4,
      64'd10, 64'd15, 1'b1, 1'b0, 4'd3},
    '{32'h13C, 2'd2, 2'd0, 64'hFFFF_FFFF, 64'd0, 64'd1, 1'b1, 26'd7,
      64'd1, 64'd0, 1'b1, 1'b0, 4'd0},
    '{32'h13D, 2'd2, 2'd1, 64'hAABB_CCDD, 64'd0, 64'h1122_3344, 1'b1, 26'd4,
      64'h1122_3344, 64'hAABB_CCDD, 1'b1, 1'b1, 4'd4},
    '{32'h200, 2'd3, 2'd2, 64'h99, 64'h77, 64'h77, 1'b0, 26'd8,
      64'h77, 64'h99, 1'b1, 1'b0, 4'd0},
    '{32'h200, 2'd3, 2'd2, 64'h99, 64'h77, 64'h78, 1'b1, 26'd8,
      64'h78, 64'h0, 1'b0, 1'b0, 4'd3},
    '{32'h23F, 2'd0, 2'd0, 64'd1, 64'd0, 64'hFF, 1'b1, 26'd9,
      64'hFF, 64'h00, 1'b1, 1'b0, 4'd0},
    '{32'h23F, 2'd1, 2'd2, 64'hBEEF, 64'h1234, 64'h1234, 1'b1, 26'd9,
      64'h1234, 64'hBEEF, 1'b1, 1'b1, 4'd4},
    '{32'h300, 2'd1, 2'd1, 64'h1_5555, 64'd0, 64'hFFFF_0000_0000_ABCD, 1'b1, 26'd12,
      64'hABCD, 64'h5555, 1'b1, 1'b0, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [1:0]        req_op = '0;
  logic [DATA_W-1:0] req_operand = '0;
  logic [DATA_W-1:0] req_compare = '0;
  logic              rsp_done;
  logic [DATA_W-1:0] rsp_old;
  logic              acq_req;
  logic [LINE_W-1:0] acq_line;
  logic              acq_gnt;
  logic              mem_rd, mem_wr;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0]        mem_size;
  logic [DATA_W-1:0] mem_wr_data;
  logic [DATA_W-1:0] mem_rd_data;
  logic              snp_valid = 1'b0;
  logic [LINE_W-1:0] snoop_line = '0;
  logic              snp_stall;
  logic              bus_lock_req;
  logic              bus_lock_gnt;
  logic              bus_lock;

  atomic_rmw_lockctl dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_op(req_op), .req_operand(req_operand),
    .req_compare(req_compare), .rsp_done(rsp_done), .rsp_old(rsp_old),
    .acq_req(acq_req), .acq_line(acq_line), .acq_gnt(acq_gnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
    .snp_valid(snp_valid), .snoop_line(snoop_line), .snp_stall(snp_stall),
    .bus_lock_req(bus_lock_req), .bus_lock_gnt(bus_lock_gnt), .bus_lock(bus_lock)
  );

  // Cache and arbiter models
  logic [DATA_W-1:0] cur_mem = '0;
  logic              rd_vld;
  logic              hold_gnt = 1'b0;
  logic [1:0]        acq_cnt, bl_cnt_g;

  always @(posedge clk) begin
    if (rst) begin
      rd_vld   <= 1'b0;
      acq_cnt  <= '0;
      bl_cnt_g <= '0;
    end else begin
      rd_vld   <= mem_rd;
      acq_cnt  <= (acq_req && !hold_gnt) ? ((acq_cnt == 2'd3) ? acq_cnt : acq_cnt + 2'd1) : 2'd0;
      bl_cnt_g <= (bus_lock_req && !hold_gnt) ? ((bl_cnt_g == 2'd3) ? bl_cnt_g : bl_cnt_g + 2'd1) : 2'd0;
    end
  end
  assign mem_rd_data  = rd_vld ? cur_mem : POISON;
  assign acq_gnt      = (acq_cnt >= 2'd2);
  assign bus_lock_gnt = (bl_cnt_g >= 2'd2);

  // Monitor, sampled at the falling edge
  int          n_stall, n_lock, n_wr;
  logic        seen_acq;
  logic [DATA_W-1:0] wr_seen;
  always @(negedge clk) begin
    if (!rst) begin
      if (snp_stall) n_stall++;
      if (bus_lock) n_lock++;
      if (acq_req) seen_acq = 1'b1;
      if (mem_wr) begin
        n_wr++;
        wr_seen = mem_wr_data;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    n_stall = 0; n_lock = 0; n_wr = 0; seen_acq = 1'b0; wr_seen = '0;
    cur_mem     = v.mem;
    snp_valid   = v.snp_on;
    snoop_line  = v.snp_line;
    req_addr    = v.addr;
    req_size    = v.size;
    req_op      = v.op;
    req_operand = v.opnd;
    req_compare = v.cmp;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic [DATA_W-1:0] old_v, output logic ok);
    ok = 1'b0;
    old_v = '0;
    for (int i = 0; i < 60; i++) begin
      if (rsp_done) begin
        old_v = rsp_old;
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [DATA_W-1:0] old_v;
    logic ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 ready", req_ready, 1);
    check("R11 quiet", {rsp_done, acq_req, mem_rd, mem_wr, bus_lock_req, bus_lock, snp_stall}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 ready after reset", req_ready, 1);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NVEC; k++) begin
      issue(VEC[k]);
      wait_done(old_v, ok);
      check($sformatf("R10 done v%0d", k), ok, 1);
      check($sformatf("R8 old v%0d", k), old_v, VEC[k].exp_old);
      check($sformatf("R9 writes v%0d", k), n_wr, VEC[k].exp_wr ? 1 : 0);
      if (VEC[k].exp_wr) check($sformatf("R8 new v%0d", k), wr_seen, VEC[k].exp_new);
      check($sformatf("R6 R7 split path v%0d", k), {seen_acq, n_lock == 4}, VEC[k].exp_split ? 2'b01 : 2'b10);
      check($sformatf("R4 R5 stall cycles v%0d", k), n_stall, VEC[k].exp_stall);
      snp_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R10 ready again v%0d", k), req_ready, 1);
    end

    // R1 R2: back-pressure while the grant is withheld
    hold_gnt = 1'b1;
    issue('{32'h400, 2'd2, 2'd0, 64'd3, 64'd0, 64'd4, 1'b1, 26'd16,
            64'd4, 64'd7, 1'b1, 1'b0, 4'd3});
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready low while busy", req_ready, 0);
    check("R2 acq held with line", {acq_req, acq_line}, {1'b1, 26'd16});
    check("R2 no read before grant", mem_rd, 0);
    check("R5 no stall before grant", n_stall, 0);
    req_valid = 1'b0;
    hold_gnt = 1'b0;
    wait_done(old_v, ok);
    check("R1 done after release", ok, 1);
    check("R8 add result", wr_seen, 64'd7);
    check("R4 stall window", n_stall, 3);
    snp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 single op taken", {req_ready, rsp_done, acq_req}, 3'b100);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule